// File: doc/BRIEF.md
# Video-Mode Display Packet Header Sequencer

This block produces, one header at a time, the ordered list of serial-display packet headers that make up one video frame. Software-style timing numbers arrive as plain inputs: the line counts of the four vertical regions (sync, back porch, active, front porch), the byte widths of the horizontal sync, back-porch and front-porch areas, the active width in pixels, and a filler length. A start pulse in video mode captures all of them. The block then walks the frame line by line and presents each header on a valid/ready port. It never moves pixel data, computes ECC or checksums, or drives a lane. It only decides which packet comes next and what its length field holds.

Several per-frame options change the walk. There are skip flags for each horizontal area, an option to follow the line-start event with a horizontal sync end on vertical blanking lines, and a choice between burst filling and non-burst filling (pixel packet plus a null packet). Another option drops the end-of-transmission packet. An automatic vertical count mode leaves out the sync and back-porch lines. A one-cycle done pulse marks the end of each frame.

Top module: `vidpkt_seq`

## Requirements
- R1: While reset is high, and in the cycle after it, pkt_valid and frame_done are 0.
- R2: Every header is {word count[15:0] in bits 23:8, virtual channel[1:0] in bits 7:6, data type[5:0] in bits 5:0}, and the channel is the vchan value captured at frame start.
- R3: A vertical blanking line opens with 0x01 on the first sync line, 0x11 on the first back-porch line and 0x21 otherwise, all with word count 0. When hse_vblank=1, a 0x31 header with word count 0 follows on each such line.
- R4: An active line is sent in this order: 0x21, blanking 0x19 (hsync width), 0x31, blanking 0x19 (back-porch width), pixel packet, null packet, blanking 0x19 (front-porch width), end-of-transmission. Lines run in region order sync, back porch, active, front porch, and a region with zero lines is left out.
- R5: skip_hsa removes both the hsync blanking packet and the 0x31 from active lines. skip_hbp removes the back-porch blanking packet and skip_hfp removes the front-porch blanking packet.
- R6: With burst_fill=0, a null packet 0x09 with word count null_wc follows each pixel packet. With burst_fill=1, no null packet is sent.
- R7: The pixel packet type and word count depend on pix_fmt and the active width h. Code 0 gives 0x0e and 2h. Code 1 gives 0x1e and floor(9h/4). Code 2 gives 0x2e and 3h. Code 3 gives 0x3e and 3h.
- R8: Each line ends with 0x08 and word count 0 unless eot_off=1, in which case no 0x08 is sent.
- R9: With auto_vcount=1, the frame contains no sync or back-porch lines: only active lines and then front-porch lines.
- R10: While pkt_valid=1 and pkt_ready=0, pkt_valid and pkt_hdr hold their values.
- R11: frame_done pulses for one cycle, in the cycle after the last header is accepted. If the captured line counts total zero, it pulses in the cycle after the start pulse and no header is sent.
- R12: With video_mode=0, start is ignored: no header and no frame_done appear.
- R13: Changing any configuration input during a frame has no effect on that frame.
- R14: A start pulse during a frame is ignored and does not begin another frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (single-cycle pulse) |
| video_mode | input | 1 | 1 = video sequencing, 0 = command mode (idle) |
| vchan | input | 2 | Virtual channel placed in every header |
| pix_fmt | input | 2 | Pixel format code (see R7) |
| burst_fill | input | 1 | 1 = burst, 0 = pixel plus null filling |
| hse_vblank | input | 1 | Send horizontal sync end on vertical blanking lines |
| skip_hsa | input | 1 | Leave out the horizontal sync area |
| skip_hbp | input | 1 | Leave out the horizontal back-porch area |
| skip_hfp | input | 1 | Leave out the horizontal front-porch area |
| auto_vcount | input | 1 | Ignore the sync and back-porch line counts |
| eot_off | input | 1 | Suppress end-of-transmission packets |
| v_sync_lines | input | LINE_W | Vertical sync line count |
| v_back_lines | input | LINE_W | Vertical back-porch line count |
| v_active_lines | input | LINE_W | Active line count |
| v_front_lines | input | LINE_W | Vertical front-porch line count |
| h_sync_wc | input | WC_W | Hsync blanking word count |
| h_back_wc | input | WC_W | Back-porch blanking word count |
| h_active_px | input | PX_W | Active width in pixels |
| h_front_wc | input | WC_W | Front-porch blanking word count |
| null_wc | input | WC_W | Null packet word count in non-burst mode |
| pkt_valid | output | 1 | Header available |
| pkt_ready | input | 1 | Consumer accepts the header |
| pkt_hdr | output | WC_W+8 | Header word (see R2) |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The main check runs whole frames under a table of option sets. One is a plain burst frame with full porches. One mixes non-burst null filling, blanking-line sync ends and an irregular ready pattern. One skips the sync and front areas with end-of-transmission off. Others cover automatic vertical counting with a back-porch skip, a single active line with every area skipped, and a frame that starts in the back porch. Each set separates a different branch of the step order: which line-start type is chosen, which optional packets drop out, and how each pixel format converts width to bytes. Directed runs add command mode, empty frames (including one that auto counting empties), mid-frame changes to the inputs with a repeated start, and ready stalls that must freeze the header.

// File: rtl/vidpkt_pkg.sv
package vidpkt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LSTART, ST_HSA, ST_HSE, ST_HBP, ST_PIX, ST_NUL, ST_HFP, ST_EOT
  } step_t;

  typedef enum logic [1:0] {
    RG_VSYNC, RG_VBACK, RG_ACTIVE, RG_VFRONT
  } region_t;

  localparam logic [5:0] DT_VSS   = 6'h01;
  localparam logic [5:0] DT_VSE   = 6'h11;
  localparam logic [5:0] DT_HSS   = 6'h21;
  localparam logic [5:0] DT_HSE   = 6'h31;
  localparam logic [5:0] DT_EOT   = 6'h08;
  localparam logic [5:0] DT_NULL  = 6'h09;
  localparam logic [5:0] DT_BLANK = 6'h19;

  typedef struct packed {
    logic burst;
    logic hse_vblank;
    logic skip_hsa;
    logic skip_hbp;
    logic skip_hfp;
    logic eot_off;
  } lineflags_t;

  // Whether a step takes part in a line of the given kind.
  function automatic logic step_on(step_t s, logic active, lineflags_t f);
    case (s)
      ST_HSA:  return active && !f.skip_hsa;
      ST_HSE:  return active ? !f.skip_hsa : f.hse_vblank;
      ST_HBP:  return active && !f.skip_hbp;
      ST_PIX:  return active;
      ST_NUL:  return active && !f.burst;
      ST_HFP:  return active && !f.skip_hfp;
      ST_EOT:  return !f.eot_off;
      default: return 1'b0;
    endcase
  endfunction

  // Next enabled step after cur within one line; ST_IDLE means the line is over.
  function automatic step_t step_after(step_t cur, logic active, lineflags_t f);
    step_t r;
    r = ST_IDLE;
    for (int i = int'(ST_EOT); i > int'(cur); i--) begin
      if (step_on(step_t'(4'(i)), active, f)) r = step_t'(4'(i));
    end
    return r;
  endfunction

  function automatic logic [5:0] pixel_dt(logic [1:0] fmt);
    case (fmt)
      2'd0:    return 6'h0e;
      2'd1:    return 6'h1e;
      2'd2:    return 6'h2e;
      default: return 6'h3e;
    endcase
  endfunction

endpackage

// File: rtl/vidpkt_vtiming.sv
module vidpkt_vtiming
  import vidpkt_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic [LINE_W-1:0] cnt_vs,
  input  logic [LINE_W-1:0] cnt_vb,
  input  logic [LINE_W-1:0] cnt_va,
  input  logic [LINE_W-1:0] cnt_vf,
  output region_t           region,
  output logic              first_line,
  output logic              last_line,
  output logic              empty
);

  localparam int NREG = 4;

  logic [LINE_W-1:0] live  [NREG];
  logic [LINE_W-1:0] cnt_q [NREG];
  logic [LINE_W-1:0] line_q;
  region_t           rg_q;
  region_t           nxt_rg;
  region_t           load_rg;
  logic              nz_after;
  logic              region_end;

  assign live[0] = cnt_vs;
  assign live[1] = cnt_vb;
  assign live[2] = cnt_va;
  assign live[3] = cnt_vf;

  always_comb begin
    nxt_rg   = rg_q;
    nz_after = 1'b0;
    load_rg  = RG_VSYNC;
    empty    = 1'b1;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (i > int'(rg_q) && cnt_q[i] != '0) begin
        nxt_rg   = region_t'(2'(i));
        nz_after = 1'b1;
      end
      if (live[i] != '0) begin
        load_rg = region_t'(2'(i));
        empty   = 1'b0;
      end
    end
  end

  assign region_end = (line_q == LINE_W'(cnt_q[rg_q] - 1'b1));
  assign region     = rg_q;
  assign first_line = (line_q == '0);
  assign last_line  = region_end && !nz_after;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_cnt
      always_ff @(posedge clk) begin
        if (rst)       cnt_q[g] <= '0;
        else if (load) cnt_q[g] <= live[g];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rg_q   <= RG_VSYNC;
      line_q <= '0;
    end else if (load) begin
      rg_q   <= load_rg;
      line_q <= '0;
    end else if (adv) begin
      if (region_end) begin
        rg_q   <= nxt_rg;
        line_q <= '0;
      end else begin
        line_q <= line_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/vidpkt_hdr_enc.sv
module vidpkt_hdr_enc
  import vidpkt_pkg::*;
#(
  parameter int WC_W = 16,
  parameter int PX_W = 12
) (
  input  step_t           step,
  input  region_t         region,
  input  logic            first_line,
  input  logic [1:0]      vchan,
  input  logic [1:0]      pix_fmt,
  input  logic [WC_W-1:0] hsa_wc,
  input  logic [WC_W-1:0] hbp_wc,
  input  logic [WC_W-1:0] hfp_wc,
  input  logic [WC_W-1:0] null_wc,
  input  logic [PX_W-1:0] hact,
  output logic [WC_W+7:0] hdr
);

  localparam int EXT_W = PX_W + 4;

  logic [EXT_W-1:0] ext;
  logic [EXT_W-1:0] pix_bytes;
  logic [5:0]       dt;
  logic [WC_W-1:0]  wc;

  assign ext = EXT_W'(hact);

  always_comb begin
    case (pix_fmt)
      2'd0:    pix_bytes = ext << 1;
      2'd1:    pix_bytes = ((ext << 3) + ext) >> 2;
      default: pix_bytes = (ext << 1) + ext;
    endcase
  end

  always_comb begin
    dt = DT_HSS;
    wc = '0;
    case (step)
      ST_LSTART: begin
        if (first_line && region == RG_VSYNC)      dt = DT_VSS;
        else if (first_line && region == RG_VBACK) dt = DT_VSE;
        else                                       dt = DT_HSS;
      end
      ST_HSA: begin dt = DT_BLANK; wc = hsa_wc; end
      ST_HSE: dt = DT_HSE;
      ST_HBP: begin dt = DT_BLANK; wc = hbp_wc; end
      ST_PIX: begin dt = pixel_dt(pix_fmt); wc = WC_W'(pix_bytes); end
      ST_NUL: begin dt = DT_NULL; wc = null_wc; end
      ST_HFP: begin dt = DT_BLANK; wc = hfp_wc; end
      ST_EOT: dt = DT_EOT;
      default: dt = '0;
    endcase
  end

  assign hdr = {wc, vchan, dt};

endmodule

// File: rtl/vidpkt_seq.sv
module vidpkt_seq
  import vidpkt_pkg::*;
#(
  parameter int LINE_W = 12,
  parameter int WC_W   = 16,
  parameter int PX_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              video_mode,
  input  logic [1:0]        vchan,
  input  logic [1:0]        pix_fmt,
  input  logic              burst_fill,
  input  logic              hse_vblank,
  input  logic              skip_hsa,
  input  logic              skip_hbp,
  input  logic              skip_hfp,
  input  logic              auto_vcount,
  input  logic              eot_off,
  input  logic [LINE_W-1:0] v_sync_lines,
  input  logic [LINE_W-1:0] v_back_lines,
  input  logic [LINE_W-1:0] v_active_lines,
  input  logic [LINE_W-1:0] v_front_lines,
  input  logic [WC_W-1:0]   h_sync_wc,
  input  logic [WC_W-1:0]   h_back_wc,
  input  logic [PX_W-1:0]   h_active_px,
  input  logic [WC_W-1:0]   h_front_wc,
  input  logic [WC_W-1:0]   null_wc,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  output logic [WC_W+7:0]   pkt_hdr,
  output logic              frame_done
);

  localparam int HDR_W = WC_W + 8;

  logic              valid_q;
  logic              done_q;
  step_t             step_q;
  step_t             nxt_step;
  lineflags_t        flags_q;
  logic [1:0]        vc_q;
  logic [1:0]        fmt_q;
  logic [WC_W-1:0]   hsa_q, hbp_q, hfp_q, nul_q;
  logic [PX_W-1:0]   hact_q;

  region_t           region;
  logic              first_line;
  logic              last_line;
  logic              empty;
  logic              go;
  logic              take;
  logic              line_over;
  logic [LINE_W-1:0] eff_vs;
  logic [LINE_W-1:0] eff_vb;
  logic [HDR_W-1:0]  hdr_c;

  assign eff_vs    = auto_vcount ? '0 : v_sync_lines;
  assign eff_vb    = auto_vcount ? '0 : v_back_lines;
  assign go        = start && video_mode && !valid_q;
  assign take      = valid_q && pkt_ready;
  assign nxt_step  = step_after(step_q, region == RG_ACTIVE, flags_q);
  assign line_over = take && (nxt_step == ST_IDLE);

  vidpkt_vtiming #(.LINE_W(LINE_W)) u_vt (
    .clk        (clk),
    .rst        (rst),
    .load       (go),
    .adv        (line_over && !last_line),
    .cnt_vs     (eff_vs),
    .cnt_vb     (eff_vb),
    .cnt_va     (v_active_lines),
    .cnt_vf     (v_front_lines),
    .region     (region),
    .first_line (first_line),
    .last_line  (last_line),
    .empty      (empty)
  );

  vidpkt_hdr_enc #(.WC_W(WC_W), .PX_W(PX_W)) u_enc (
    .step       (step_q),
    .region     (region),
    .first_line (first_line),
    .vchan      (vc_q),
    .pix_fmt    (fmt_q),
    .hsa_wc     (hsa_q),
    .hbp_wc     (hbp_q),
    .hfp_wc     (hfp_q),
    .null_wc    (nul_q),
    .hact       (hact_q),
    .hdr        (hdr_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      vc_q    <= '0;
      fmt_q   <= '0;
      hsa_q   <= '0;
      hbp_q   <= '0;
      hfp_q   <= '0;
      nul_q   <= '0;
      hact_q  <= '0;
    end else if (go) begin
      flags_q <= '{burst: burst_fill, hse_vblank: hse_vblank, skip_hsa: skip_hsa,
                   skip_hbp: skip_hbp, skip_hfp: skip_hfp, eot_off: eot_off};
      vc_q    <= vchan;
      fmt_q   <= pix_fmt;
      hsa_q   <= h_sync_wc;
      hbp_q   <= h_back_wc;
      hfp_q   <= h_front_wc;
      nul_q   <= null_wc;
      hact_q  <= h_active_px;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      step_q  <= ST_IDLE;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        if (empty) begin
          done_q <= 1'b1;
        end else begin
          valid_q <= 1'b1;
          step_q  <= ST_LSTART;
        end
      end else if (take) begin
        if (nxt_step != ST_IDLE) begin
          step_q <= nxt_step;
        end else if (last_line) begin
          valid_q <= 1'b0;
          step_q  <= ST_IDLE;
          done_q  <= 1'b1;
        end else begin
          step_q <= ST_LSTART;
        end
      end
    end
  end

  assign pkt_valid  = valid_q;
  assign pkt_hdr    = valid_q ? hdr_c : '0;
  assign frame_done = done_q;

endmodule

// File: rtl/vidpkt_seq_chk.sv
module vidpkt_seq_chk #(
  parameter int WC_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            video_mode,
  input logic            pkt_valid,
  input logic            pkt_ready,
  input logic [WC_W+7:0] pkt_hdr,
  input logic            frame_done
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!pkt_valid && !frame_done));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_hdr)));

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !pkt_valid);

  assert_done_cause_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_done) |-> ($past(pkt_valid && pkt_ready) || $past(start && video_mode)));

  assert_cmd_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    (!pkt_valid && !video_mode) |=> !pkt_valid);

  assert_eot_len_R8: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && pkt_hdr[5:0] == 6'h08) |-> (pkt_hdr[WC_W+7:8] == '0));

endmodule

bind vidpkt_seq vidpkt_seq_chk #(.WC_W(WC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .video_mode (video_mode),
  .pkt_valid  (pkt_valid),
  .pkt_ready  (pkt_ready),
  .pkt_hdr    (pkt_hdr),
  .frame_done (frame_done)
);

// File: tb/vidpkt_seq_tb.sv
module vidpkt_seq_tb;

  localparam int LINE_W = 12;
  localparam int WC_W   = 16;
  localparam int PX_W   = 12;
  localparam int HDR_W  = WC_W + 8;
  localparam int MAXP   = 512;

  typedef struct packed {
    logic [1:0] vc;
    logic [1:0] fmt;
    logic burst, hse, shsa, shbp, shfp, autov, eotoff;
    logic [3:0] vs, vb, va, vf;
    logic [7:0] hsa, hbp, hact, hfp, nul, pat;
  } cfg_t;

  // vc fmt burst hse shsa shbp shfp auto eotoff | vs vb va vf | hsa hbp hact hfp null | ready pattern
  localparam cfg_t TBL [6] = '{
    '{2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 4'd2, 4'd3, 4'd2, 8'd4, 8'd8, 8'd10, 8'd6, 8'd0,  8'hFF},
    '{2'd1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 4'd2, 4'd2, 4'd1, 8'd4, 8'd8, 8'd8,  8'd6, 8'd20, 8'hB5},
    '{2'd2, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd1, 4'd1, 4'd2, 4'd1, 8'd4, 8'd8, 8'd5,  8'd6, 8'd0,  8'hFF},
    '{2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd3, 4'd3, 4'd2, 4'd2, 8'd4, 8'd8, 8'd7,  8'd6, 8'd12, 8'h6D},
    '{2'd0, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, 4'd1, 4'd0, 8'd1, 8'd1, 8'd4,  8'd1, 8'd0,  8'hFF},
    '{2'd1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd3, 4'd1, 4'd0, 8'd3, 8'd5, 8'd6,  8'd2, 8'd0,  8'hDB}
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              start, video_mode;
  logic [1:0]        vchan, pix_fmt;
  logic              burst_fill, hse_vblank, skip_hsa, skip_hbp, skip_hfp, auto_vcount, eot_off;
  logic [LINE_W-1:0] v_sync_lines, v_back_lines, v_active_lines, v_front_lines;
  logic [WC_W-1:0]   h_sync_wc, h_back_wc, h_front_wc, null_wc;
  logic [PX_W-1:0]   h_active_px;
  logic              pkt_valid, pkt_ready, frame_done;
  logic [HDR_W-1:0]  pkt_hdr;

  int total = 0;
  int bad   = 0;

  logic [HDR_W-1:0] exp_q [MAXP];
  logic [HDR_W-1:0] got_q [MAXP];
  int n_exp, n_got, done_at, last_acc, stall_err;

  always #2.5ns clk = ~clk;

  vidpkt_seq #(.LINE_W(LINE_W), .WC_W(WC_W), .PX_W(PX_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .video_mode(video_mode),
    .vchan(vchan), .pix_fmt(pix_fmt), .burst_fill(burst_fill), .hse_vblank(hse_vblank),
    .skip_hsa(skip_hsa), .skip_hbp(skip_hbp), .skip_hfp(skip_hfp),
    .auto_vcount(auto_vcount), .eot_off(eot_off),
    .v_sync_lines(v_sync_lines), .v_back_lines(v_back_lines),
    .v_active_lines(v_active_lines), .v_front_lines(v_front_lines),
    .h_sync_wc(h_sync_wc), .h_back_wc(h_back_wc), .h_active_px(h_active_px),
    .h_front_wc(h_front_wc), .null_wc(null_wc),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_hdr(pkt_hdr), .frame_done(frame_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(logic [5:0] dt);
    case (dt)
      6'h01, 6'h11, 6'h21, 6'h31: return "R3";
      6'h19: return "R5";
      6'h09: return "R6";
      6'h08: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input cfg_t c);
    vchan = c.vc; pix_fmt = c.fmt; burst_fill = c.burst; hse_vblank = c.hse;
    skip_hsa = c.shsa; skip_hbp = c.shbp; skip_hfp = c.shfp;
    auto_vcount = c.autov; eot_off = c.eotoff;
    v_sync_lines = LINE_W'(c.vs); v_back_lines = LINE_W'(c.vb);
    v_active_lines = LINE_W'(c.va); v_front_lines = LINE_W'(c.vf);
    h_sync_wc = WC_W'(c.hsa); h_back_wc = WC_W'(c.hbp);
    h_active_px = PX_W'(c.hact); h_front_wc = WC_W'(c.hfp); null_wc = WC_W'(c.nul);
  endtask

  task automatic push(input cfg_t c, input logic [5:0] dt, input int wc);
    exp_q[n_exp] = {16'(wc), c.vc, dt};
    n_exp++;
  endtask

  // Independent model of the frame, written from the requirements.
  task automatic build_expect(input cfg_t c);
    int cnt [4];
    int h, pwc;
    logic [5:0] pdt;
    n_exp = 0;
    cnt[0] = c.autov ? 0 : int'(c.vs);
    cnt[1] = c.autov ? 0 : int'(c.vb);
    cnt[2] = int'(c.va);
    cnt[3] = int'(c.vf);
    h = int'(c.hact);
    case (c.fmt)
      2'd0: begin pdt = 6'h0e; pwc = 2 * h; end
      2'd1: begin pdt = 6'h1e; pwc = (9 * h) / 4; end
      2'd2: begin pdt = 6'h2e; pwc = 3 * h; end
      default: begin pdt = 6'h3e; pwc = 3 * h; end
    endcase
    for (int r = 0; r < 4; r++) begin
      for (int l = 0; l < cnt[r]; l++) begin
        if (r == 0 && l == 0)      push(c, 6'h01, 0);
        else if (r == 1 && l == 0) push(c, 6'h11, 0);
        else                       push(c, 6'h21, 0);
        if (r == 2) begin
          if (!c.shsa) begin push(c, 6'h19, int'(c.hsa)); push(c, 6'h31, 0); end
          if (!c.shbp) push(c, 6'h19, int'(c.hbp));
          push(c, pdt, pwc);
          if (!c.burst) push(c, 6'h09, int'(c.nul));
          if (!c.shfp) push(c, 6'h19, int'(c.hfp));
        end else if (c.hse) begin
          push(c, 6'h31, 0);
        end
        if (!c.eotoff) push(c, 6'h08, 0);
      end
    end
  endtask

  task automatic run_frame(input logic [7:0] pat, input bit mutate);
    logic [HDR_W-1:0] prev_hdr;
    bit prev_stall;
    n_got = 0; done_at = -1; last_acc = -1; stall_err = 0;
    prev_stall = 0; prev_hdr = '0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 4000; k++) begin
      if (frame_done) begin done_at = k; break; end
      if (prev_stall && pkt_hdr != prev_hdr) stall_err++;
      if (prev_stall && !pkt_valid) stall_err++;
      if (mutate && k == 3) begin
        vchan = ~vchan; h_active_px = h_active_px + 1'b1; skip_hfp = ~skip_hfp;
        burst_fill = ~burst_fill; eot_off = ~eot_off; v_active_lines = '0;
        start = 1'b1;
      end
      if (mutate && k == 4) start = 1'b0;
      pkt_ready = pat[k % 8];
      if (pkt_valid && pkt_ready) begin
        if (n_got < MAXP) got_q[n_got] = pkt_hdr;
        n_got++;
        last_acc = k;
      end
      prev_stall = pkt_valid && !pkt_ready;
      prev_hdr = pkt_hdr;
      @(negedge clk);
    end
    pkt_ready = 1'b1;
  endtask

  task automatic compare(input cfg_t c, input bit mutate);
    string cl;
    cl = mutate ? "R13" : (c.autov ? "R9" : "R4");
    check(n_got == n_exp, cl, "header count", 32'(n_got), 32'(n_exp));
    for (int i = 0; i < n_exp && i < n_got; i++)
      check(got_q[i] == exp_q[i], mutate ? "R13" : req_of(exp_q[i][5:0]),
            $sformatf("header %0d", i), 32'(got_q[i]), 32'(exp_q[i]));
    if (n_got > 0)
      check(got_q[0][7:6] == c.vc, "R2", "channel field", 32'(got_q[0][7:6]), 32'(c.vc));
    check(done_at == last_acc + 1 && done_at >= 0, "R11", "done timing",
          32'(done_at), 32'(last_acc + 1));
    check(stall_err == 0, "R10", "header held under stall", 32'(stall_err), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cfg_t z;
    rst = 1'b1; start = 1'b0; video_mode = 1'b0; pkt_ready = 1'b1;
    apply(TBL[0]);
    repeat (3) @(negedge clk);
    check(!pkt_valid && !frame_done, "R1", "outputs in reset",
          {30'd0, pkt_valid, frame_done}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!pkt_valid && !frame_done, "R1", "outputs after reset",
          {30'd0, pkt_valid, frame_done}, 32'd0);

    // R12: command mode ignores start
    video_mode = 1'b0;
    run_frame(8'hFF, 1'b0);
    check(n_got == 0 && done_at < 0, "R12", "command mode activity",
          32'(n_got), 32'd0);

    // Table of option sets, each a whole frame
    video_mode = 1'b1;
    for (int t = 0; t < 6; t++) begin
      apply(TBL[t]);
      build_expect(TBL[t]);
      run_frame(TBL[t].pat, 1'b0);
      compare(TBL[t], 1'b0);
      repeat (3) @(negedge clk);
    end

    // R13 / R14: inputs change and start repeats mid-frame
    apply(TBL[1]);
    build_expect(TBL[1]);
    run_frame(8'hF7, 1'b1);
    compare(TBL[1], 1'b1);
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (pkt_valid || frame_done) seen++;
      end
      check(seen == 0, "R14", "activity after repeated start", 32'(seen), 32'd0);
    end

    // R11: zero-line frame
    z = TBL[0];
    z.vs = 4'd0; z.vb = 4'd0; z.va = 4'd0; z.vf = 4'd0;
    apply(z);
    run_frame(8'hFF, 1'b0);
    check(n_got == 0 && done_at == 0, "R11", "empty frame done cycle",
          32'(done_at), 32'd0);

    // R9 corner: auto vertical count empties a frame of sync/back lines only
    z.vs = 4'd2; z.vb = 4'd1; z.autov = 1'b1;
    apply(z);
    run_frame(8'hFF, 1'b0);
    check(n_got == 0 && done_at == 0, "R9", "auto count drops sync and back lines",
          32'(n_got), 32'd0);

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule